// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces byte addresses for a data buffer kept in memory. The buffer is a window described by four registers: a starting address (base), a window size in bytes (length), a signed step in bytes (modify) and the current pointer (index). Software loads them through a plain one-word write port. Each access strobe presents the current index as the memory address. On the following clock edge the index moves by the signed step, and it folds back into the window when it would leave it. No software action is needed once the registers hold their values.

The folded next index is also shown combinationally, so a caller can see where the following access will land in the same cycle. Steps may be positive or negative and need not equal one element. A buffer of 32-bit words simply uses steps in multiples of 4. A length of zero turns folding off, and the pointer then moves linearly. The step magnitude must not exceed the length, so a single add or subtract of the length always brings the pointer back inside the window.

The access strobe and the register port are control pins. No data stream crosses the block, so there is no back-pressure: every strobe is taken in the cycle it is raised.

Top module: `circ_agen`

## Requirements
- R1: After reset, index, base, length and modify are all 0, so `addr_o` and `next_o` read 0.
- R2: `addr_o` always equals the current index. When `acc_i` is 1 and `cfg_we_i` is 0, the index takes the value shown on `next_o` at the next rising clock edge.
- R3: With a nonzero length, if index + modify ≥ base + length, then `next_o` = index + modify − length. Equality also folds.
- R4: With a nonzero length, if index + modify < base, then `next_o` = index + modify + length. A sum equal to base does not fold.
- R5: With a nonzero length and a sum inside [base, base + length), `next_o` = index + modify. This holds for steps of any size up to the length.
- R6: With a length of 0, `next_o` = index + modify (modulo 2^AW) for either sign of modify.
- R7: A write with `cfg_we_i` = 1 stores `cfg_wdata_i` into the register picked by `cfg_sel_i`: 0 = index, 1 = base, 2 = length, 3 = modify. Modify is read as two's complement. The new value is in use from the next cycle on.
- R8: When `cfg_we_i` and `acc_i` are both 1 in one cycle, the write is applied and the index update of that strobe is discarded.
- R9: With `acc_i` = 0 and no index write, the index holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 2 | Register select: 0 index, 1 base, 2 length, 3 modify |
| cfg_wdata_i | input | AW | Register write value |
| acc_i | input | 1 | Access strobe |
| addr_o | output | AW | Address of the current access (current index) |
| next_o | output | AW | Folded index the next access will use |

## Verification
The hardest cases to reach from the ports are the exact-boundary sums. In one, index plus step lands precisely on base plus length and must fold. In the other, it lands precisely on base and must not. The stimulus reaches both by choosing window sizes and steps that walk the pointer onto these values within a few strobes, in both directions. The other hard case is a register write that arrives in the same cycle as a strobe. The bench drives the write and the strobe in the same cycle, then reads the address on the following cycle to show that the write took effect and the step did not.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;

  typedef enum logic [1:0] {
    SEL_INDEX  = 2'd0,
    SEL_BASE   = 2'd1,
    SEL_LENGTH = 2'd2,
    SEL_MODIFY = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/circ_agen_cfg.sv
module circ_agen_cfg
  import circ_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic          idx_we,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] mod_q
);

  cfg_sel_e sel_e;
  assign sel_e  = cfg_sel_e'(sel);
  assign idx_we = we && (sel_e == SEL_INDEX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      mod_q  <= '0;
    end else if (we) begin
      case (sel_e)
        SEL_BASE:   base_q <= wdata;
        SEL_LENGTH: len_q  <= wdata;
        SEL_MODIFY: mod_q  <= wdata;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/circ_agen_fold.sv
module circ_agen_fold #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] modv,
  output logic [AW-1:0] nxt
);

  localparam int EW = AW + 2;

  logic signed [EW-1:0] idx_x, base_x, len_x, mod_x;
  logic signed [EW-1:0] sum_x, end_x, fold_x;
  logic                 wrap_off, over_top, under_base;

  assign idx_x  = signed'({2'b00, idx});
  assign base_x = signed'({2'b00, base});
  assign len_x  = signed'({2'b00, len});
  assign mod_x  = signed'({{2{modv[AW-1]}}, modv});

  assign sum_x      = idx_x + mod_x;
  assign end_x      = base_x + len_x;
  assign wrap_off   = (len == '0);
  assign over_top   = (sum_x >= end_x);
  assign under_base = (sum_x < base_x);

  always_comb begin
    fold_x = sum_x;
    if (!wrap_off) begin
      if (over_top)        fold_x = sum_x - len_x;
      else if (under_base) fold_x = sum_x + len_x;
    end
  end

  assign nxt = fold_x[AW-1:0];

endmodule

// File: rtl/circ_agen_index.sv
module circ_agen_index #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_we,
  input  logic          idx_we,
  input  logic [AW-1:0] wdata,
  input  logic          acc,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] idx_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (idx_we)     idx_q <= wdata;
    else if (acc && !any_we) idx_q <= nxt;
  end

endmodule

// File: rtl/circ_agen.sv
module circ_agen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          acc_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);

  logic          idx_we;
  logic [AW-1:0] base_q, len_q, mod_q, idx_q, nxt;

  circ_agen_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .sel(cfg_sel_i),
    .wdata(cfg_wdata_i), .idx_we(idx_we),
    .base_q(base_q), .len_q(len_q), .mod_q(mod_q)
  );

  circ_agen_fold #(.AW(AW)) u_fold (
    .idx(idx_q), .base(base_q), .len(len_q), .modv(mod_q), .nxt(nxt)
  );

  circ_agen_index #(.AW(AW)) u_index (
    .clk(clk), .rst_n(rst_n), .any_we(cfg_we_i), .idx_we(idx_we),
    .wdata(cfg_wdata_i), .acc(acc_i), .nxt(nxt), .idx_q(idx_q)
  );

  assign addr_o = idx_q;
  assign next_o = nxt;

endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we_i,
  input logic [1:0]    cfg_sel_i,
  input logic [AW-1:0] cfg_wdata_i,
  input logic          acc_i,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] next_o,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] len_q,
  input logic [AW-1:0] mod_q
);

  logic [AW:0] lo, hi, cur, nx;
  logic [AW-1:0] mag;
  logic in_win, nx_in_win, fits;

  assign mag       = mod_q[AW-1] ? (~mod_q + 1'b1) : mod_q;
  assign fits      = (mag <= len_q) && (len_q != '0);
  assign lo        = {1'b0, base_q};
  assign hi        = {1'b0, base_q} + {1'b0, len_q};
  assign cur       = {1'b0, addr_o};
  assign nx        = {1'b0, next_o};
  assign in_win    = (cur >= lo) && (cur < hi);
  assign nx_in_win = (nx >= lo) && (nx < hi);

  // R2: strobe without write moves the address to the shown next index
  a_r2_step_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !cfg_we_i) |=> (addr_o == $past(next_o)));

  // R3/R4/R5: inside the window a legal step stays inside the window
  a_r3_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (fits && in_win) |-> nx_in_win);

  // R6: zero length means a plain linear step
  a_r6_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0) |-> (next_o == addr_o + mod_q));

  // R7/R8: an index write is visible next cycle, strobe or not
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_sel_i == 2'd0) |=> (addr_o == $past(cfg_wdata_i)));

  // R8: a non-index write during a strobe leaves the index alone
  a_r8_step_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_sel_i != 2'd0) |=> $stable(addr_o));

  // R9: no strobe, no write, index holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_i && !cfg_we_i) |=> $stable(addr_o));

endmodule

bind circ_agen circ_agen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
  .cfg_wdata_i(cfg_wdata_i), .acc_i(acc_i), .addr_o(addr_o), .next_o(next_o),
  .base_q(base_q), .len_q(len_q), .mod_q(mod_q)
);

// File: tb/test_circ_agen.sv
module test_circ_agen;
  localparam int AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_sel_i = 2'd0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          acc_i = 1'b0;
  logic [AW-1:0] addr_o, next_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_agen #(.AW(AW)) i_circ_agen (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .acc_i(acc_i), .addr_o(addr_o), .next_o(next_o)
  );

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one cycle: optional write and optional strobe, driven after negedge
  task automatic cycle(input bit we, input logic [1:0] sel,
                       input logic [AW-1:0] d, input bit acc);
    @(negedge clk);
    cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = d; acc_i = acc;
    @(negedge clk);
    cfg_we_i = 1'b0; acc_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    cycle(1'b1, sel, d, 1'b0);
  endtask

  task automatic setup(input logic [AW-1:0] b, input logic [AW-1:0] l,
                       input logic [AW-1:0] m, input logic [AW-1:0] i);
    wr(2'd1, b); wr(2'd2, l); wr(2'd3, m); wr(2'd0, i);
  endtask

  // check address and shown next index, then strobe once
  task automatic step(input string req, input logic [AW-1:0] ea,
                      input logic [AW-1:0] en);
    @(negedge clk);
    acc_i = 1'b1;
    #1;
    check({req, " addr"}, addr_o, ea);
    check({req, " next"}, next_o, en);
    @(negedge clk);
    acc_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset addr", addr_o, '0);
    check("R1 reset next", next_o, '0);
  endtask

  task automatic t_forward;
    setup(32'h0, 32'd44, 32'd16, 32'h0);
    step("R5 fwd", 32'h00, 32'h10);
    step("R5 fwd", 32'h10, 32'h20);
    step("R3 fwd wrap", 32'h20, 32'h04);
    step("R2 fwd", 32'h04, 32'h14);
    @(negedge clk);
    check("R2 after step", addr_o, 32'h14);
    // exact top boundary folds (R3)
    setup(32'h40, 32'd12, 32'd8, 32'h40);
    step("R5 small", 32'h40, 32'h48);
    step("R3 over top", 32'h48, 32'h44);
    step("R3 equal top", 32'h44, 32'h40);
  endtask

  task automatic t_backward;
    setup(32'h100, 32'd16, 32'hFFFF_FFFC, 32'h100);
    step("R4 under base", 32'h100, 32'h10C);
    step("R5 down", 32'h10C, 32'h108);
    step("R5 down", 32'h108, 32'h104);
    step("R4 equal base no fold", 32'h104, 32'h100);
  endtask

  task automatic t_linear;
    setup(32'h0, 32'd0, 32'd4, 32'h200);
    step("R6 linear up", 32'h200, 32'h204);
    wr(2'd3, 32'hFFFF_FFF8);
    step("R6 linear down", 32'h204, 32'h1FC);
  endtask

  task automatic t_collision;
    setup(32'h0, 32'd44, 32'd16, 32'h10);
    cycle(1'b1, 2'd0, 32'h08, 1'b1);
    #1 check("R8 index write beats strobe", addr_o, 32'h08);
    cycle(1'b1, 2'd3, 32'd4, 1'b1);
    #1 check("R8 strobe dropped on modify write", addr_o, 32'h08);
    check("R7 new modify in use", next_o, 32'h0C);
  endtask

  task automatic t_hold;
    setup(32'h0, 32'd44, 32'd16, 32'h24);
    repeat (3) @(negedge clk);
    check("R9 hold", addr_o, 32'h24);
    check("R7 base/len readback via next", next_o, 32'h08);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_forward();
    t_backward();
    t_linear();
    t_collision();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule